// File: doc/BRIEF.md
# Configurable AND/OR Logic Plane with Complement Feedback

This block is a combinational sum-of-products plane whose connections come from a configuration register instead of fuses. Its literals are four dedicated inputs, four pin readbacks and eight register feedbacks. From these it forms 32 logic product terms and 13 control product terms.

A complement signal is the NOR of a chosen set of logic terms. Any term may add the inverse of that signal as one more literal. The plane drives four pin sums, each with its own output inversion. Four of the control terms act as pin direction enables. All logic and control terms are also exported for the flip-flop stage that sits outside this block.

The configuration is loaded one bit per clock while `prog_en` is high. During loading, the outputs hold the last values they had before loading started.

Top module: `pla_plane`

## Requirements
- R1: After reset the configuration is all zero. With `prog_en` low and any inputs, every bit of `term_out` and `ctrl_out` is 1, `b_out` is 0, `b_oe` is 4'hF and `cfg_err` is 0.
- R2: On each rising clock edge with `prog_en` high, the configuration vector `cfg` (width CW=1649) shifts left by one bit and takes `cfg_in` into bit 0. A vector is therefore loaded MSB first in 1649 clocks.
- R3: Term t (0..31 logic, 32..44 control) occupies `cfg[t*33 +: 33]`. The literals are numbered k = 0..15: inputs `in_i[0..3]` are k = 0..3, `pin_b[0..3]` are k = 4..7, and `reg_q[0..7]` are k = 8..15. Bit 2k selects the true form of literal k and bit 2k+1 selects its complement. A term with no selected literals is 1. A term with both bits set for any literal is 0.
- R4: The complement signal C is 0 when any logic term whose bit `cfg[1485+t]` is set is 1; otherwise C is 1. Bit 32 of a term's field adds the literal "not C" to that term.
- R5: `cfg_err` is 1 exactly when some logic term is selected into the NOR and also has its "not C" bit set. The NOR then uses that term as if its "not C" bit were clear, while the term's own output still applies "not C".
- R6: `b_out[p]` is the OR of the logic terms t whose bit `cfg[1517+32*p+t]` is set, XORed with the polarity bit `cfg[1645+p]`. With no terms selected, `b_out[p]` equals the polarity bit.
- R7: `b_oe[p]` equals control term 32+p.
- R8: `term_out` carries logic terms 0..31 and `ctrl_out` carries control terms 32..44, in index order.
- R9: While `prog_en` is high, all outputs keep the values they had at the last rising edge at which `prog_en` was low. This holds whatever the inputs and `cfg_in` do.
- R10: While `prog_en` is low, `cfg_in` has no effect and the configuration is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration loading and output hold |
| rst_n | input | 1 | Active-low reset; clears configuration and hold register |
| prog_en | input | 1 | High while configuration bits are shifted in |
| cfg_in | input | 1 | Serial configuration data |
| in_i | input | 4 | Dedicated inputs |
| pin_b | input | 4 | Pin readback values |
| reg_q | input | 8 | Register feedback values |
| b_out | output | 4 | Pin sum outputs after polarity |
| b_oe | output | 4 | Pin direction enables |
| term_out | output | 32 | Logic product terms |
| ctrl_out | output | 13 | Control product terms |
| cfg_err | output | 1 | Complement feedback loop violation |

## Verification
The bench loads directed and random configurations and compares every output against a model after each input change. It aims at the following corner cases:
- Terms with both literal bits set. A design that ORs the two bits would output 1 instead of 0.
- Empty sums with inverted polarity. A wrong design would drive 0 instead of 1.
- Terms that use "not C" while the NOR selection is empty or active. A design that inverted C, or fed it back through the NOR, would flip those terms.
- Configurations that violate the loop rule. Here `cfg_err` must rise and C must ignore the offending literal.

Inputs are toggled during loading to catch outputs that leak through the hold, and `cfg_in` is toggled with `prog_en` low to catch a configuration that keeps shifting.

// File: rtl/pla_plane.sv
module pla_plane #(
  parameter int NI  = 4,
  parameter int NB  = 4,
  parameter int NQ  = 8,
  parameter int NLT = 32,
  parameter int NCT = 13
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           prog_en,
  input  logic           cfg_in,
  input  logic [NI-1:0]  in_i,
  input  logic [NB-1:0]  pin_b,
  input  logic [NQ-1:0]  reg_q,
  output logic [NB-1:0]  b_out,
  output logic [NB-1:0]  b_oe,
  output logic [NLT-1:0] term_out,
  output logic [NCT-1:0] ctrl_out,
  output logic           cfg_err
);
  localparam int NL    = NI + NB + NQ;
  localparam int TW    = 2 * NL + 1;
  localparam int NT    = NLT + NCT;
  localparam int SEL_B = NT * TW;
  localparam int OR_B  = SEL_B + NLT;
  localparam int POL_B = OR_B + NB * NLT;
  localparam int CW    = POL_B + NB;
  localparam int OW    = 2 * NB + NT + 1;

  logic [CW-1:0] cfg;
  logic [NL-1:0] lits;
  logic [NT-1:0] raw, usec, terms;
  logic [NLT-1:0] nsel;
  logic [NB-1:0] sum;
  logic          c;
  logic          err;
  logic [OW-1:0] live, held;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       cfg <= '0;
    else if (prog_en) cfg <= {cfg[CW-2:0], cfg_in};

  assign lits = {reg_q, pin_b, in_i};

  always_comb begin
    raw = '1;
    for (int t = 0; t < NT; t++)
      for (int k = 0; k < NL; k++) begin
        if (cfg[t*TW + 2*k]     && !lits[k]) raw[t] = 1'b0;
        if (cfg[t*TW + 2*k + 1] &&  lits[k]) raw[t] = 1'b0;
      end
  end

  genvar g;
  generate
    for (g = 0; g < NT; g++) begin : g_usec
      assign usec[g] = cfg[g*TW + 2*NL];
    end
    for (g = 0; g < NB; g++) begin : g_sum
      assign sum[g] = (|(terms[NLT-1:0] & cfg[OR_B + g*NLT +: NLT])) ^ cfg[POL_B + g];
    end
  endgenerate

  assign nsel  = cfg[SEL_B +: NLT];
  assign c     = ~|(raw[NLT-1:0] & nsel);
  assign terms = raw & ~(usec & {NT{c}});
  assign err   = |(nsel & usec[NLT-1:0]);

  assign live = {sum, terms[NLT +: NB], terms, err};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        held <= '0;
    else if (!prog_en) held <= live;

  assign {b_out, b_oe, ctrl_out, term_out, cfg_err} = prog_en ? held : live;
endmodule

// File: rtl/pla_plane_chk.sv
module pla_plane_chk #(
  parameter int NB    = 4,
  parameter int NLT   = 32,
  parameter int NCT   = 13,
  parameter int CW    = 1649,
  parameter int SEL_B = 1485,
  parameter int OR_B  = 1517,
  parameter int POL_B = 1645
) (
  input logic           clk,
  input logic           rst_n,
  input logic           prog_en,
  input logic           cfg_in,
  input logic [CW-1:0]  cfg,
  input logic           c,
  input logic [NB-1:0]  b_out,
  input logic [NB-1:0]  b_oe,
  input logic [NLT-1:0] term_out,
  input logic [NCT-1:0] ctrl_out
);
  AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    prog_en && $past(prog_en) |-> $stable({b_out, b_oe, term_out, ctrl_out})); // R9

  AST_CFG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_en |=> $stable(cfg)); // R10

  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
    prog_en |=> cfg[0] == $past(cfg_in)); // R2

  AST_C_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg[SEL_B +: NLT] == '0 |-> c); // R4

  genvar p;
  generate
    for (p = 0; p < NB; p++) begin : g_pol
      AST_EMPTY_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_en && cfg[OR_B + p*NLT +: NLT] == '0 |-> b_out[p] == cfg[POL_B + p]); // R6
    end
  endgenerate
endmodule

bind pla_plane pla_plane_chk #(
  .NB(NB), .NLT(NLT), .NCT(NCT), .CW(CW), .SEL_B(SEL_B), .OR_B(OR_B), .POL_B(POL_B)
) u_chk (
  .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .cfg_in(cfg_in), .cfg(cfg), .c(c),
  .b_out(b_out), .b_oe(b_oe), .term_out(term_out), .ctrl_out(ctrl_out)
);

// File: tb/pla_plane_tb.sv
module pla_plane_tb;
  localparam int CLK_P = 10;
  localparam int NI = 4, NB = 4, NQ = 8, NLT = 32, NCT = 13;
  localparam int NL = NI + NB + NQ;
  localparam int TW = 2 * NL + 1;
  localparam int NT = NLT + NCT;
  localparam int SEL_B = NT * TW;
  localparam int OR_B = SEL_B + NLT;
  localparam int POL_B = OR_B + NB * NLT;
  localparam int CW = POL_B + NB;
  localparam int OW = 2 * NB + NT + 1;

  logic clk = 0, rst_n = 0, prog_en = 0, cfg_in = 0;
  logic [NI-1:0] ii = '0;
  logic [NB-1:0] bb = '0;
  logic [NQ-1:0] qq = '0;
  logic [NB-1:0] b_out, b_oe;
  logic [NLT-1:0] term_out;
  logic [NCT-1:0] ctrl_out;
  logic cfg_err;
  logic [CW-1:0] cv_cur = '0, cv;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  pla_plane u_dut (.clk(clk), .rst_n(rst_n), .prog_en(prog_en), .cfg_in(cfg_in),
    .in_i(ii), .pin_b(bb), .reg_q(qq), .b_out(b_out), .b_oe(b_oe),
    .term_out(term_out), .ctrl_out(ctrl_out), .cfg_err(cfg_err));

  function automatic logic [OW-1:0] model(input logic [CW-1:0] m, input logic [NI-1:0] vi,
                                          input logic [NB-1:0] vb, input logic [NQ-1:0] vq);
    logic [NL-1:0] lv;
    logic [NT-1:0] pt;
    logic [NB-1:0] s;
    logic cc, e, o;
    lv = {vq, vb, vi};
    for (int t = 0; t < NT; t++) begin
      pt[t] = 1'b1;
      for (int k = 0; k < NL; k++)
        case ({m[t*TW + 2*k + 1], m[t*TW + 2*k]})
          2'b01: if (!lv[k]) pt[t] = 1'b0;
          2'b10: if (lv[k]) pt[t] = 1'b0;
          2'b11: pt[t] = 1'b0;
          default: ;
        endcase
    end
    cc = 1'b1; e = 1'b0;
    for (int t = 0; t < NLT; t++)
      if (m[SEL_B + t]) begin
        if (pt[t]) cc = 1'b0;
        if (m[t*TW + 2*NL]) e = 1'b1;
      end
    for (int t = 0; t < NT; t++)
      if (m[t*TW + 2*NL] && cc) pt[t] = 1'b0;
    for (int p = 0; p < NB; p++) begin
      o = 1'b0;
      for (int t = 0; t < NLT; t++) if (m[OR_B + p*NLT + t] && pt[t]) o = 1'b1;
      s[p] = o ^ m[POL_B + p];
    end
    return {s, pt[NLT +: NB], pt, e};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cmp_all(input logic [OW-1:0] e, input string ctx);
    chk({"R6 b_out ", ctx}, 64'(b_out), 64'(e[OW-1 -: NB]));
    chk({"R7 b_oe ", ctx}, 64'(b_oe), 64'(e[OW-NB-1 -: NB]));
    chk({"R8 ctrl_out ", ctx}, 64'(ctrl_out), 64'(e[NLT+1 +: NCT]));
    chk({"R3 R4 term_out ", ctx}, 64'(term_out), 64'(e[1 +: NLT]));
    chk({"R5 cfg_err ", ctx}, 64'(cfg_err), 64'(e[0]));
  endtask

  task automatic rand_in();
    ii = NI'($urandom); bb = NB'($urandom); qq = NQ'($urandom);
  endtask

  task automatic vec(input string ctx);
    @(negedge clk);
    #1 cmp_all(model(cv_cur, ii, bb, qq), ctx);
  endtask

  // R2 load, R9 hold while loading
  task automatic load(input logic [CW-1:0] nv);
    logic [OW-1:0] hexp;
    @(negedge clk);
    hexp = model(cv_cur, ii, bb, qq);
    prog_en = 1'b1;
    for (int i = CW - 1; i >= 0; i--) begin
      cfg_in = nv[i];
      rand_in();
      #1;
      if (i == CW - 1 || i % 400 == 0) cmp_all(hexp, "R9 hold");
      @(negedge clk);
    end
    prog_en = 1'b0;
    cv_cur = nv;
  endtask

  task automatic run_vectors(input int n, input string ctx);
    for (int j = 0; j < n; j++) begin
      rand_in();
      vec(ctx);
    end
    ii = '0; bb = '0; qq = '0; vec({ctx, " zeros"});
    ii = '1; bb = '1; qq = '1; vec({ctx, " ones"});
  endtask

  function automatic logic [CW-1:0] rand_cfg(input bit allow_err);
    logic [CW-1:0] m;
    m = '0;
    for (int t = 0; t < NT; t++) begin
      for (int b = 0; b < 2*NL; b++) m[t*TW + b] = ($urandom % 14) == 0;
      m[t*TW + 2*NL] = ($urandom % 4) == 0;
    end
    for (int t = 0; t < NLT; t++) begin
      m[SEL_B + t] = ($urandom % 4) == 0;
      if (!allow_err && m[SEL_B + t]) m[t*TW + 2*NL] = 1'b0;
    end
    for (int b = 0; b < NB*NLT; b++) m[OR_B + b] = ($urandom % 6) == 0;
    for (int p = 0; p < NB; p++) m[POL_B + p] = $urandom % 2;
    return m;
  endfunction

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rand_in();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R1 reset state
    chk("R1 term_out", 64'(term_out), 64'({NLT{1'b1}}));
    chk("R1 ctrl_out", 64'(ctrl_out), 64'({NCT{1'b1}}));
    chk("R1 b_out", 64'(b_out), 64'(0));
    chk("R1 b_oe", 64'(b_oe), 64'({NB{1'b1}}));
    chk("R1 cfg_err", 64'(cfg_err), 64'(0));

    // Directed: R3 encodings, R4 complement, R6 polarity, R7 direction
    cv = '0;
    cv[0] = 1'b1;                        // term0: in_i[0] true
    cv[3] = 1'b1;                        // term0: in_i[1] complement
    cv[TW + 4] = 1'b1; cv[TW + 5] = 1'b1; // term1: both forms -> 0 (R3)
    cv[3*TW + 2*NL] = 1'b1;              // term3 uses not C (R4)
    cv[SEL_B + 0] = 1'b1;                // C = NOR(term0)
    cv[OR_B + 0] = 1'b1; cv[OR_B + 1] = 1'b1;
    cv[POL_B + 1] = 1'b1;                // empty sum, inverted -> 1 (R6)
    cv[OR_B + 2*NLT + 3] = 1'b1; cv[POL_B + 2] = 1'b1;
    cv[NLT*TW + 2*15] = 1'b1;            // ctrl term 32 = reg_q[7] -> b_oe[0] (R7)
    load(cv);
    ii = 4'b0001; bb = '0; qq = 8'h80; vec("directed C=0");
    chk("R4 term3 with C low", 64'(term_out[3]), 64'(1));
    chk("R6 inverted empty sum", 64'(b_out[1]), 64'(1));
    chk("R7 oe from reg_q7", 64'(b_oe[0]), 64'(1));
    ii = 4'b0000; qq = 8'h00; vec("directed C=1");
    chk("R4 term3 with C high", 64'(term_out[3]), 64'(0));
    chk("R3 forced zero term", 64'(term_out[1]), 64'(0));
    chk("R3 empty term", 64'(term_out[2]), 64'(1));
    run_vectors(60, "directed");

    // R10: cfg_in ignored while prog_en low
    for (int j = 0; j < 40; j++) begin
      @(negedge clk);
      cfg_in = $urandom % 2;
    end
    run_vectors(20, "R10 after idle cfg_in");

    // Directed loop violation (R5)
    cv = '0;
    cv[SEL_B + 0] = 1'b1;
    cv[0*TW + 2*NL] = 1'b1;
    cv[OR_B + 0] = 1'b1;
    load(cv);
    run_vectors(10, "R5 violation");
    chk("R5 flag high", 64'(cfg_err), 64'(1));

    for (int r = 0; r < 12; r++) begin
      load(rand_cfg(r % 4 == 3));
      run_vectors(150, "random");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule